// File: doc/BRIEF.md
# Power-Down Sequencer

This block sequences a clock generator into and out of its low-power state. An asynchronous active-low power-down request is first brought into the base clock domain. Each controlled clock group is then parked low at the end of its current cycle. Only after every group is parked does the block turn the VCO off, and then the crystal oscillator. The reference-rate outputs are parked at once, outside the per-group sequence. While the request is active, the serial configuration port is tristated and the per-group stop requests have no effect.

On release, the oscillator and VCO are re-enabled together. All clock groups stay parked low until a stabilization wait has counted a fixed number of reference-clock ticks. This count is reloaded on every wake. If the request returns during the wait, the block goes straight back to shutdown. The wait then starts over on the next release.

A separate registered decoder sets the output-state controls from the output-enable pin and a two-bit function field. Output-enable low always wins.

Top module: `pwrdn_sequencer`

## Requirements
- R1: `pd_req_n` passes through a two-stage synchronizer. Take edge k as the first rising edge at which it is sampled low. Then `ref_hold` and `port_tristate` first read 1 after edge k+2, and both still read 0 after edge k+1.
- R2: During shutdown, a group's `hold_low` bit rises only on an edge where that group's `cycle_end` bit is 1. A group whose `cycle_end` stays 0 keeps `hold_low` at 0.
- R3: `vco_en` falls on the edge after the one where the last `hold_low` bit rises. `osc_en` falls on the following edge, and never before `vco_en`.
- R4: With every `cycle_end` bit held at 1, all `hold_low` bits read 1 after edge k+3, which is two base clock periods after the synchronized request.
- R5: `ref_hold` rises at edge k+2, whatever the state of `cycle_end`, before any group is held.
- R6: On release, `osc_en` and `vco_en` are both 1 after the third edge at which `pd_req_n` is sampled high. `port_tristate` and all `hold_low` bits stay 1 until WAKE_TICKS `ref_tick` pulses have been counted during the wait. `port_tristate` drops on the next edge. The holds drop at the edge after that, when `cycle_end` is 1. The count restarts from WAKE_TICKS on every wake.
- R7: If `pd_req_n` is sampled low again during the wait, `vco_en` falls two edges later and `osc_en` one edge after that. All `hold_low` bits stay 1 throughout.
- R8: In run, a low on `stop_req_n[i]` (bit 0 for group 0, bit 1 for group 1) sets `hold_low[i]` at the third edge that samples it, given `cycle_end[i]`=1. Releasing the request clears the hold with the same timing. Stop requests raised and released during power-down leave no effect: all holds clear after the wake.
- R9: `port_tristate` is 1 from the first shutdown edge until the wait ends, and 0 in run.
- R10: `oe`=0 sampled at an edge gives `out_tristate`=1, `test_mode`=0 and `spread_en`=0 after that edge, for any `func_sel`.
- R11: With `oe`=1, `func_sel` decodes after one edge as follows: 2'b11 sets `out_tristate`, 2'b10 sets `spread_en`, 2'b01 sets `test_mode`, and 2'b00 sets none of them. At most one of the three is ever 1.
- R12: After reset, `osc_en`=1, `vco_en`=1, all `hold_low`=0, `ref_hold`=0, `port_tristate`=0, and all three mode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| stop_req_n | input | NSTOP | Per-group stop requests, active low, asynchronous |
| cycle_end | input | NGRP | Per-group end-of-cycle indication from the dividers |
| ref_tick | input | 1 | One-cycle strobe per reference clock period |
| oe | input | 1 | Output enable pin |
| func_sel | input | 2 | Function field from the configuration register |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| hold_low | output | NGRP | Per-group hold-low command |
| ref_hold | output | 1 | Hold-low command for reference-rate outputs |
| port_tristate | output | 1 | Tristate for the serial configuration pins |
| out_tristate | output | 1 | Tristate for all clock outputs |
| test_mode | output | 1 | Test clock mode select |
| spread_en | output | 1 | Spread-spectrum enable |

## Verification
Shutdown is first driven with one group withholding its end-of-cycle indication. This separates per-group parking from a global hold, and shows that the VCO waits for the last group. A second shutdown with every indication present pins the minimum latency. Wake-up runs with random `ref_tick` gaps, which tells tick counting apart from cycle counting. A wake is also aborted after a few ticks and then repeated in full, which exposes a counter that is not reloaded. The mode decoder gets every field value with the enable both high and low, then random pairs, so a wrong priority or a swapped code shows up.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_VCO_OFF = 3'd2,
    ST_DOWN    = 3'd3,
    ST_WAKE    = 3'd4
  } pd_state_t;

  localparam logic [1:0] FN_NORMAL   = 2'b00;
  localparam logic [1:0] FN_TEST     = 2'b01;
  localparam logic [1:0] FN_SPREAD   = 2'b10;
  localparam logic [1:0] FN_TRISTATE = 2'b11;

endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pwrdn_hold_bank.sv
module pwrdn_hold_bank #(
  parameter int NGRP  = 3,
  parameter int NSTOP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_hold,
  input  logic             drain,
  input  logic             run,
  input  logic [NSTOP-1:0] stop_act,
  input  logic [NGRP-1:0]  cycle_end,
  output logic [NGRP-1:0]  hold
);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic want_g;
    logic hold_r;

    if (g < NSTOP) begin : g_stoppable
      assign want_g = drain | (run & stop_act[g]);
    end else begin : g_fixed
      assign want_g = drain;
    end

    // park or release only at the group's own cycle boundary
    always_ff @(posedge clk) begin
      if (rst)               hold_r <= 1'b0;
      else if (force_hold)   hold_r <= 1'b1;
      else if (cycle_end[g]) hold_r <= want_g;
    end

    assign hold[g] = hold_r;
  end

endmodule

// File: rtl/pwrdn_wake_timer.sv
module pwrdn_wake_timer #(
  parameter int TICKS = 42955
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic active,
  input  logic ref_tick,
  output logic done
);

  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(TICKS);
    else if (active && ref_tick && (cnt != '0))
      cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/pwrdn_mode_dec.sv
module pwrdn_mode_dec
  import pwrdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       oe,
  input  logic [1:0] func_sel,
  output logic       out_tristate,
  output logic       test_mode,
  output logic       spread_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_tristate <= 1'b0;
      test_mode    <= 1'b0;
      spread_en    <= 1'b0;
    end else begin
      out_tristate <= !oe || (func_sel == FN_TRISTATE);
      test_mode    <= oe && (func_sel == FN_TEST);
      spread_en    <= oe && (func_sel == FN_SPREAD);
    end
  end

endmodule

// File: rtl/pwrdn_sequencer.sv
module pwrdn_sequencer
  import pwrdn_pkg::*;
#(
  parameter int NGRP       = 3,
  parameter int NSTOP      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_TICKS = 42955
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_req_n,
  input  logic [NSTOP-1:0] stop_req_n,
  input  logic [NGRP-1:0]  cycle_end,
  input  logic             ref_tick,
  input  logic             oe,
  input  logic [1:0]       func_sel,
  output logic             osc_en,
  output logic             vco_en,
  output logic [NGRP-1:0]  hold_low,
  output logic             ref_hold,
  output logic             port_tristate,
  output logic             out_tristate,
  output logic             test_mode,
  output logic             spread_en
);

  pd_state_t        state_q, state_d;
  logic             pd_s;
  logic [NSTOP-1:0] stop_s;
  logic             pd_act;
  logic             wake_done;
  logic             force_hold;

  pwrdn_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst(rst), .d(pd_req_n), .q(pd_s)
  );

  pwrdn_sync #(.WIDTH(NSTOP), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst(rst), .d(stop_req_n), .q(stop_s)
  );

  assign pd_act     = !pd_s;
  assign force_hold = (state_q == ST_VCO_OFF) || (state_q == ST_DOWN) ||
                      (state_q == ST_WAKE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (pd_act) state_d = ST_DRAIN;
      ST_DRAIN:   if (&hold_low) state_d = ST_VCO_OFF;
      ST_VCO_OFF: state_d = ST_DOWN;
      ST_DOWN:    if (!pd_act) state_d = ST_WAKE;
      ST_WAKE: begin
        if (pd_act)         state_d = ST_VCO_OFF;
        else if (wake_done) state_d = ST_RUN;
      end
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_RUN;
      osc_en        <= 1'b1;
      vco_en        <= 1'b1;
      ref_hold      <= 1'b0;
      port_tristate <= 1'b0;
    end else begin
      state_q       <= state_d;
      osc_en        <= (state_d != ST_DOWN);
      vco_en        <= (state_d == ST_RUN) || (state_d == ST_DRAIN) ||
                       (state_d == ST_WAKE);
      ref_hold      <= (state_d != ST_RUN);
      port_tristate <= (state_d != ST_RUN);
    end
  end

  pwrdn_hold_bank #(.NGRP(NGRP), .NSTOP(NSTOP)) u_holds (
    .clk        (clk),
    .rst        (rst),
    .force_hold (force_hold),
    .drain      (state_q == ST_DRAIN),
    .run        (state_q == ST_RUN),
    .stop_act   (~stop_s),
    .cycle_end  (cycle_end),
    .hold       (hold_low)
  );

  pwrdn_wake_timer #(.TICKS(WAKE_TICKS)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .load     ((state_q == ST_DOWN) && !pd_act),
    .active   (state_q == ST_WAKE),
    .ref_tick (ref_tick),
    .done     (wake_done)
  );

  pwrdn_mode_dec u_mode (
    .clk          (clk),
    .rst          (rst),
    .oe           (oe),
    .func_sel     (func_sel),
    .out_tristate (out_tristate),
    .test_mode    (test_mode),
    .spread_en    (spread_en)
  );

endmodule

// File: rtl/pwrdn_sequencer_chk.sv
module pwrdn_sequencer_chk #(
  parameter int NGRP = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            oe,
  input logic            osc_en,
  input logic            vco_en,
  input logic [NGRP-1:0] hold_low,
  input logic            ref_hold,
  input logic            port_tristate,
  input logic            out_tristate,
  input logic            test_mode,
  input logic            spread_en
);

  assert_osc_needs_vco_off_R3: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !vco_en);

  assert_vco_off_all_held_R3: assert property (@(posedge clk) disable iff (rst)
    !vco_en |-> ((&hold_low) && ref_hold));

  assert_vco_falls_first_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(vco_en) |-> osc_en);

  assert_wake_starts_held_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_en) |-> (&hold_low));

  assert_ref_with_port_R5: assert property (@(posedge clk) disable iff (rst)
    ref_hold |-> port_tristate);

  assert_run_all_on_R9: assert property (@(posedge clk) disable iff (rst)
    !port_tristate |-> (osc_en && vco_en));

  assert_oe_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(oe)) |-> (out_tristate && !test_mode && !spread_en));

  assert_modes_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_tristate, test_mode, spread_en}));

endmodule

bind pwrdn_sequencer pwrdn_sequencer_chk #(.NGRP(NGRP)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .oe            (oe),
  .osc_en        (osc_en),
  .vco_en        (vco_en),
  .hold_low      (hold_low),
  .ref_hold      (ref_hold),
  .port_tristate (port_tristate),
  .out_tristate  (out_tristate),
  .test_mode     (test_mode),
  .spread_en     (spread_en)
);

// File: tb/pwrdn_sequencer_tb.sv
`timescale 1ns/1ps
module pwrdn_sequencer_tb;

  localparam int NGRP  = 3;
  localparam int NSTOP = 2;
  localparam int WAKE  = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic             pd_req_n;
  logic [NSTOP-1:0] stop_req_n;
  logic [NGRP-1:0]  cycle_end;
  logic             ref_tick;
  logic             oe;
  logic [1:0]       func_sel;
  logic             osc_en, vco_en, ref_hold, port_tristate;
  logic             out_tristate, test_mode, spread_en;
  logic [NGRP-1:0]  hold_low;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwrdn_sequencer #(.NGRP(NGRP), .NSTOP(NSTOP), .SYNC_STAGES(2), .WAKE_TICKS(WAKE)) u_dut (
    .clk(clk), .rst(rst), .pd_req_n(pd_req_n), .stop_req_n(stop_req_n),
    .cycle_end(cycle_end), .ref_tick(ref_tick), .oe(oe), .func_sel(func_sel),
    .osc_en(osc_en), .vco_en(vco_en), .hold_low(hold_low), .ref_hold(ref_hold),
    .port_tristate(port_tristate), .out_tristate(out_tristate),
    .test_mode(test_mode), .spread_en(spread_en)
  );

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mode(input logic e, input logic [1:0] f);
    // {out_tristate, test_mode, spread_en}
    if (!e)          return 3'b100;
    if (f == 2'b11)  return 3'b100;
    if (f == 2'b10)  return 3'b001;
    if (f == 2'b01)  return 3'b010;
    return 3'b000;
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // release and run a full stabilization wait with random tick gaps
  task automatic full_wake(input string req);
    int got;
    pd_req_n = 1'b1;
    ref_tick = 1'b0;
    step(2);
    chk(req, "osc still off before sync", int'(osc_en), 0);
    step(1);
    chk(req, "osc on at wake", int'(osc_en), 1);
    chk(req, "vco on at wake", int'(vco_en), 1);
    chk(req, "holds kept at wake", int'(hold_low), 7);
    got = 0;
    while (got < WAKE) begin
      ref_tick = 1'($urandom % 2);
      step(1);
      if (ref_tick) got++;
      chk(req, "port tristate during wait", int'(port_tristate), 1);
      chk(req, "holds during wait", int'(hold_low), 7);
    end
    ref_tick = 1'b0;
    step(1);
    chk(req, "port released after count", int'(port_tristate), 0);
    chk(req, "holds one edge later", int'(hold_low), 7);
    step(1);
    chk(req, "holds released", int'(hold_low), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [2:0] em;
    void'($urandom(32'd2024));
    rst = 1'b1; pd_req_n = 1'b1; stop_req_n = '1; cycle_end = '1;
    ref_tick = 1'b0; oe = 1'b1; func_sel = 2'b00;
    step(3);
    rst = 1'b0;
    step(1);
    // R12 reset state
    chk("R12", "osc_en", int'(osc_en), 1);
    chk("R12", "vco_en", int'(vco_en), 1);
    chk("R12", "hold_low", int'(hold_low), 0);
    chk("R12", "ref_hold", int'(ref_hold), 0);
    chk("R12", "port_tristate", int'(port_tristate), 0);
    chk("R12", "modes", int'({out_tristate, test_mode, spread_en}), 0);

    // R10 / R11 directed then random
    for (int e = 0; e < 2; e++) begin
      for (int f = 0; f < 4; f++) begin
        oe = 1'(e); func_sel = 2'(f);
        step(1);
        em = exp_mode(oe, func_sel);
        chk(e == 0 ? "R10" : "R11", "mode decode", int'({out_tristate, test_mode, spread_en}), int'(em));
      end
    end
    for (int i = 0; i < 40; i++) begin
      oe = 1'($urandom % 2); func_sel = 2'($urandom % 4);
      step(1);
      em = exp_mode(oe, func_sel);
      chk(oe ? "R11" : "R10", "random mode", int'({out_tristate, test_mode, spread_en}), int'(em));
    end
    oe = 1'b1; func_sel = 2'b00;

    // R8 stop request in run
    stop_req_n = 2'b10;
    step(2);
    chk("R8", "stop not yet synced", int'(hold_low), 0);
    step(1);
    chk("R8", "group0 parked", int'(hold_low), 1);
    stop_req_n = 2'b11;
    step(2);
    chk("R8", "still parked", int'(hold_low), 1);
    step(1);
    chk("R8", "group0 released", int'(hold_low), 0);

    // R1 R2 R3 R5 R9: shutdown with group 1 lacking its cycle end
    cycle_end = 3'b101;
    pd_req_n = 1'b0;
    step(2);
    chk("R1", "ref_hold before sync", int'(ref_hold), 0);
    chk("R9", "port before sync", int'(port_tristate), 0);
    step(1);
    chk("R1", "ref_hold after sync", int'(ref_hold), 1);
    chk("R9", "port tristated", int'(port_tristate), 1);
    chk("R5", "ref first, groups free", int'(hold_low), 0);
    step(1);
    chk("R2", "groups with cycle end parked", int'(hold_low), 5);
    step(2);
    chk("R2", "group1 waits", int'(hold_low), 5);
    chk("R3", "vco waits for group1", int'(vco_en), 1);
    cycle_end = 3'b111;
    step(1);
    chk("R2", "group1 parked", int'(hold_low), 7);
    chk("R3", "vco on same edge", int'(vco_en), 1);
    step(1);
    chk("R3", "vco off", int'(vco_en), 0);
    chk("R3", "osc still on", int'(osc_en), 1);
    step(1);
    chk("R3", "osc off", int'(osc_en), 0);

    // R8 stop requests ignored while down
    stop_req_n = 2'b00;
    step(4);
    chk("R8", "holds while down", int'(hold_low), 7);
    stop_req_n = 2'b11;
    step(4);
    full_wake("R6");
    chk("R8", "no leftover stop", int'(hold_low), 0);

    // R4 minimum latency with all cycle ends
    pd_req_n = 1'b0;
    step(3);
    chk("R4", "not yet held", int'(hold_low), 0);
    step(1);
    chk("R4", "all held", int'(hold_low), 7);
    step(2);
    chk("R4", "down", int'({osc_en, vco_en}), 0);

    // R7 abort during wait, then R6 reload
    pd_req_n = 1'b1;
    step(3);
    chk("R7", "waking", int'(vco_en), 1);
    for (int i = 0; i < 3; i++) begin
      ref_tick = 1'b1;
      step(1);
    end
    ref_tick = 1'b0;
    pd_req_n = 1'b0;
    step(2);
    chk("R7", "vco still on", int'(vco_en), 1);
    step(1);
    chk("R7", "vco off", int'(vco_en), 0);
    chk("R7", "osc on", int'(osc_en), 1);
    chk("R7", "holds kept", int'(hold_low), 7);
    step(1);
    chk("R7", "osc off", int'(osc_en), 0);
    chk("R9", "port during abort", int'(port_tristate), 1);
    step(2);
    full_wake("R6");

    summary();
  end

endmodule